// File: doc/BRIEF.md
# Boundary-Scan Test Port for a Bidirectional Pin Bank

This block puts a serial test port in front of a bank of bidirectional pins. A tester clocks the port through a four-wire serial link: a test clock, a mode-select line, a serial input and a serial output. A 16-state controller, steered by the mode-select line, walks the port through its capture, shift and update phases. During the instruction phases it loads a 3-bit instruction. During the data phases it shifts either a single bypass bit or a chain of boundary cells that sits between the core and the pads.

Each pin has three cells in the chain: one watches the pad input, one holds the output value and one holds the output enable. An enable cell holding 0 turns the pad driver off. Depending on the current instruction, the pads either follow the core's own output and enable, or are driven from the update latches of the chain, or are all released to high impedance. In normal operation the port sits in its reset state with the bypass instruction loaded, and the core owns the pins.

Top module: `bscan_port`

## Requirements
- R1: While reset is asserted, and after it is released, the controller is in its reset state. The loaded instruction is bypass (111), every pad follows the core (`pad_do = core_do`, `pad_oe = core_oe`), and `tdo_oe` and `tdo` are both 0.
- R2: Five consecutive rising TCK edges with TMS high bring the controller to the reset state from any state. That reset restores the bypass instruction and clears all update latches, so the pads go back to following the core.
- R3: In Capture-IR the instruction shift register loads 001. The first three bits shifted out of an instruction scan are therefore 1, 0, 0, least significant bit first.
- R4: Under bypass (111) the data path is one bit long. It captures 0, so a data scan returns 0 followed by the TDI bits delayed by one clock.
- R5: Codes 011 and 100 select the one-bit bypass path and leave the pads with the core, exactly like bypass.
- R6: Under sample (001) a data scan returns the captured chain while the pads keep following the core. The shifted-in pattern is loaded into the update latches at Update-DR.
- R7: Both 000 and 010 select the external-test mode. In that mode the chain is the data path and each pad takes its output from its data latch and its enable from its enable latch.
- R8: Under high-impedance (101) every `pad_oe` is 0, and the data path is the one-bit bypass register.
- R9: Under clamp (110) the pads are driven from the update latches, the data path is the bypass register, and data scans leave the latches unchanged.
- R10: TDO and its enable change only on the falling edge of TCK. `tdo_oe` is 1 only in Shift-IR and Shift-DR, and outside those states `tdo` is held at 0.
- R11: Update latches and the instruction load on the falling TCK edge inside Update-DR and Update-IR. Pads are still unchanged one half-cycle after Update-DR is entered.
- R12: The chain is 3*NPIN cells long, and cell 0 is the one nearest TDO. For pin i, cell 3i is the enable cell (it captures `core_oe[i]`), cell 3i+1 is the data cell (it captures `core_do[i]`) and cell 3i+2 is the input cell (it captures `pad_di[i]`).
- R13: `core_di` always equals `pad_di`, whatever the instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| por_n | input | 1 | Asynchronous active-low power-on reset |
| tck | input | 1 | Test clock |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, falling-edge timed |
| tdo_oe | output | 1 | High while TDO carries shift data |
| core_do | input | NPIN | Core output data per pin |
| core_oe | input | NPIN | Core output enable per pin |
| core_di | output | NPIN | Pad input returned to the core |
| pad_di | input | NPIN | Value seen at each pad |
| pad_do | output | NPIN | Data sent to each pad driver |
| pad_oe | output | NPIN | Enable for each pad driver |

## Verification
The hardest situation to reach from the ports is a return to reset from deep inside a data scan while the external-test mode owns the pads. The stimulus loads 000, parks the controller in Pause-DR, and then holds TMS high for five clocks. On the way out it passes through Update-DR, so the latches are overwritten before the reset clears them, and the bench checks that the pads end up following the core. Clamp is reached only after sample has first preloaded a known pattern. This shows that the clamp-mode data scans leave the driven values untouched.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  typedef enum logic [3:0] {
    TS_RESET   = 4'd0,
    TS_IDLE    = 4'd1,
    TS_SEL_DR  = 4'd2,
    TS_CAP_DR  = 4'd3,
    TS_SH_DR   = 4'd4,
    TS_EX1_DR  = 4'd5,
    TS_PAU_DR  = 4'd6,
    TS_EX2_DR  = 4'd7,
    TS_UPD_DR  = 4'd8,
    TS_SEL_IR  = 4'd9,
    TS_CAP_IR  = 4'd10,
    TS_SH_IR   = 4'd11,
    TS_EX1_IR  = 4'd12,
    TS_PAU_IR  = 4'd13,
    TS_EX2_IR  = 4'd14,
    TS_UPD_IR  = 4'd15
  } tap_state_t;

  localparam int IR_W = 3;
  localparam int CELLS_PER_PIN = 3;
  localparam int CELL_EN  = 0;
  localparam int CELL_DAT = 1;
  localparam int CELL_IN  = 2;

  localparam logic [IR_W-1:0] OP_EXT_A   = 3'b000;
  localparam logic [IR_W-1:0] OP_EXT_B   = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b001;
  localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
  localparam logic [IR_W-1:0] OP_HIGHZ   = 3'b101;
  localparam logic [IR_W-1:0] OP_CLAMP   = 3'b110;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import bscan_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_t state
);
  tap_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      TS_RESET:  nxt = tms ? TS_RESET  : TS_IDLE;
      TS_IDLE:   nxt = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR: nxt = tms ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: nxt = tms ? TS_EX1_DR : TS_SH_DR;
      TS_SH_DR:  nxt = tms ? TS_EX1_DR : TS_SH_DR;
      TS_EX1_DR: nxt = tms ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: nxt = tms ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: nxt = tms ? TS_UPD_DR : TS_SH_DR;
      TS_UPD_DR: nxt = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR: nxt = tms ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR: nxt = tms ? TS_EX1_IR : TS_SH_IR;
      TS_SH_IR:  nxt = tms ? TS_EX1_IR : TS_SH_IR;
      TS_EX1_IR: nxt = tms ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: nxt = tms ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: nxt = tms ? TS_UPD_IR : TS_SH_IR;
      TS_UPD_IR: nxt = tms ? TS_SEL_DR : TS_IDLE;
      default:   nxt = TS_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= TS_RESET;
    else        state <= nxt;
  end
endmodule

// File: rtl/ir_unit.sv
module ir_unit
  import bscan_pkg::*;
(
  input  logic            tck,
  input  logic            rst_n,
  input  logic            tdi,
  input  logic            cap_ir,
  input  logic            sh_ir,
  input  logic            upd_ir,
  input  logic            in_reset,
  output logic [IR_W-1:0] ir_sr,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_lsb,
  output logic            sel_bsr,
  output logic            drive_latch,
  output logic            force_off
);
  logic            sr_en;
  logic [IR_W-1:0] sr_nxt;

  // Shift stage: rising edge
  always_comb begin
    sr_en  = cap_ir | sh_ir;
    sr_nxt = cap_ir ? IR_CAPTURE : {tdi, ir_sr[IR_W-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     ir_sr <= IR_CAPTURE;
    else if (sr_en) ir_sr <= sr_nxt;
  end

  // Parallel instruction: falling edge
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)        ir_q <= OP_BYPASS;
    else if (in_reset) ir_q <= OP_BYPASS;
    else if (upd_ir)   ir_q <= ir_sr;
  end

  // Decode; unlisted codes fall to bypass behaviour
  always_comb begin
    sel_bsr     = 1'b0;
    drive_latch = 1'b0;
    force_off   = 1'b0;
    unique case (ir_q)
      OP_EXT_A, OP_EXT_B: begin sel_bsr = 1'b1; drive_latch = 1'b1; end
      OP_SAMPLE:          sel_bsr = 1'b1;
      OP_CLAMP:           drive_latch = 1'b1;
      OP_HIGHZ:           force_off = 1'b1;
      default: ;
    endcase
  end

  assign ir_lsb = ir_sr[0];
endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
  import bscan_pkg::*;
#(
  parameter int NPIN = 4
) (
  input  logic            tck,
  input  logic            rst_n,
  input  logic            tdi,
  input  logic            cap_dr,
  input  logic            sh_dr,
  input  logic            upd_dr,
  input  logic            in_reset,
  input  logic            sel_bsr,
  input  logic            drive_latch,
  input  logic            force_off,
  input  logic [NPIN-1:0] core_do,
  input  logic [NPIN-1:0] core_oe,
  input  logic [NPIN-1:0] pad_di,
  output logic [NPIN-1:0] pad_do,
  output logic [NPIN-1:0] pad_oe,
  output logic            chain_so
);
  localparam int CELLS = CELLS_PER_PIN * NPIN;

  logic [CELLS-1:0] chain_q, cap_vec, chain_nxt;
  logic             chain_en;
  logic [NPIN-1:0]  en_lat, dat_lat, en_nxt, dat_nxt;
  logic             lat_en;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    assign cap_vec[CELLS_PER_PIN*i+CELL_EN]  = core_oe[i];
    assign cap_vec[CELLS_PER_PIN*i+CELL_DAT] = core_do[i];
    assign cap_vec[CELLS_PER_PIN*i+CELL_IN]  = pad_di[i];
    assign en_nxt[i]  = chain_q[CELLS_PER_PIN*i+CELL_EN];
    assign dat_nxt[i] = chain_q[CELLS_PER_PIN*i+CELL_DAT];

    always_comb begin
      if (force_off)        pad_oe[i] = 1'b0;
      else if (drive_latch) pad_oe[i] = en_lat[i];
      else                  pad_oe[i] = core_oe[i];
      pad_do[i] = drive_latch ? dat_lat[i] : core_do[i];
    end
  end

  // Capture/shift stage: rising edge
  always_comb begin
    chain_en  = sel_bsr & (cap_dr | sh_dr);
    chain_nxt = cap_dr ? cap_vec : {tdi, chain_q[CELLS-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)        chain_q <= '0;
    else if (chain_en) chain_q <= chain_nxt;
  end

  // Update latches: falling edge, safe value 0
  assign lat_en = sel_bsr & upd_dr;

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      en_lat  <= '0;
      dat_lat <= '0;
    end else if (in_reset) begin
      en_lat  <= '0;
      dat_lat <= '0;
    end else if (lat_en) begin
      en_lat  <= en_nxt;
      dat_lat <= dat_nxt;
    end
  end

  assign chain_so = chain_q[0];
endmodule

// File: rtl/bscan_port.sv
module bscan_port
  import bscan_pkg::*;
#(
  parameter int NPIN = 4
) (
  input  logic            por_n,
  input  logic            tck,
  input  logic            tms,
  input  logic            tdi,
  output logic            tdo,
  output logic            tdo_oe,
  input  logic [NPIN-1:0] core_do,
  input  logic [NPIN-1:0] core_oe,
  output logic [NPIN-1:0] core_di,
  input  logic [NPIN-1:0] pad_di,
  output logic [NPIN-1:0] pad_do,
  output logic [NPIN-1:0] pad_oe
);
  logic [1:0]      rst_sync;
  logic            rst_n;
  tap_state_t      state;
  logic            cap_ir, sh_ir, upd_ir, cap_dr, sh_dr, upd_dr, in_reset;
  logic [IR_W-1:0] ir_sr, ir_q;
  logic            ir_lsb, sel_bsr, drive_latch, force_off;
  logic            chain_so, byp_q, byp_en, byp_nxt;
  logic            tdo_nxt, oe_nxt;

  // Reset asserts at once, releases on a TCK edge
  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n = rst_sync[1];

  tap_fsm u_fsm (
    .tck   (tck),
    .rst_n (rst_n),
    .tms   (tms),
    .state (state)
  );

  always_comb begin
    in_reset = (state == TS_RESET);
    cap_ir   = (state == TS_CAP_IR);
    sh_ir    = (state == TS_SH_IR);
    upd_ir   = (state == TS_UPD_IR);
    cap_dr   = (state == TS_CAP_DR);
    sh_dr    = (state == TS_SH_DR);
    upd_dr   = (state == TS_UPD_DR);
  end

  ir_unit u_ir (
    .tck         (tck),
    .rst_n       (rst_n),
    .tdi         (tdi),
    .cap_ir      (cap_ir),
    .sh_ir       (sh_ir),
    .upd_ir      (upd_ir),
    .in_reset    (in_reset),
    .ir_sr       (ir_sr),
    .ir_q        (ir_q),
    .ir_lsb      (ir_lsb),
    .sel_bsr     (sel_bsr),
    .drive_latch (drive_latch),
    .force_off   (force_off)
  );

  bsr_chain #(.NPIN(NPIN)) u_bsr (
    .tck         (tck),
    .rst_n       (rst_n),
    .tdi         (tdi),
    .cap_dr      (cap_dr),
    .sh_dr       (sh_dr),
    .upd_dr      (upd_dr),
    .in_reset    (in_reset),
    .sel_bsr     (sel_bsr),
    .drive_latch (drive_latch),
    .force_off   (force_off),
    .core_do     (core_do),
    .core_oe     (core_oe),
    .pad_di      (pad_di),
    .pad_do      (pad_do),
    .pad_oe      (pad_oe),
    .chain_so    (chain_so)
  );

  // One-bit bypass path
  always_comb begin
    byp_en  = ~sel_bsr & (cap_dr | sh_dr);
    byp_nxt = cap_dr ? 1'b0 : tdi;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      byp_q <= 1'b0;
    else if (byp_en) byp_q <= byp_nxt;
  end

  // Serial output: falling edge, quiet outside shift states
  always_comb begin
    oe_nxt = sh_ir | sh_dr;
    if (sh_ir)      tdo_nxt = ir_lsb;
    else if (sh_dr) tdo_nxt = sel_bsr ? chain_so : byp_q;
    else            tdo_nxt = 1'b0;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= tdo_nxt;
      tdo_oe <= oe_nxt;
    end
  end

  assign core_di = pad_di;
endmodule

// File: rtl/bscan_port_chk.sv
module bscan_port_chk
  import bscan_pkg::*;
#(
  parameter int NPIN = 4
) (
  input logic            tck,
  input logic            rst_n,
  input logic            tms,
  input tap_state_t      state,
  input logic [IR_W-1:0] ir_sr,
  input logic [IR_W-1:0] ir_q,
  input logic [NPIN-1:0] pad_oe,
  input logic            tdo,
  input logic            tdo_oe
);
  logic [2:0] ones;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)          ones <= 3'd0;
    else if (!tms)       ones <= 3'd0;
    else if (ones != 3'd5) ones <= ones + 3'd1;
  end

  p_reset_bypass_r1: assert property (@(posedge tck) disable iff (!rst_n)
    (state == TS_RESET) |=> (ir_q == OP_BYPASS));

  p_five_ones_r2: assert property (@(posedge tck) disable iff (!rst_n)
    (ones == 3'd5) |-> (state == TS_RESET));

  p_capture_ir_r3: assert property (@(posedge tck) disable iff (!rst_n)
    (state == TS_CAP_IR) |=> (ir_sr == IR_CAPTURE));

  p_highz_off_r8: assert property (@(posedge tck) disable iff (!rst_n)
    (ir_q == OP_HIGHZ) |-> (pad_oe == '0));

  p_tdo_quiet_r10: assert property (@(posedge tck) disable iff (!rst_n)
    !(state == TS_SH_DR || state == TS_SH_IR) |-> (!tdo_oe && !tdo));

  p_ir_hold_r11: assert property (@(posedge tck) disable iff (!rst_n)
    !$stable(ir_q) |-> (state == TS_UPD_IR || state == TS_RESET));
endmodule

bind bscan_port bscan_port_chk #(.NPIN(NPIN)) u_chk (
  .tck    (tck),
  .rst_n  (rst_n),
  .tms    (tms),
  .state  (state),
  .ir_sr  (ir_sr),
  .ir_q   (ir_q),
  .pad_oe (pad_oe),
  .tdo    (tdo),
  .tdo_oe (tdo_oe)
);

// File: tb/test_bscan_port.sv
module test_bscan_port;
  localparam int NPIN = 4;
  localparam int W    = 3 * NPIN;

  logic tck, por_n, tms, tdi;
  logic tdo, tdo_oe;
  logic [NPIN-1:0] core_do, core_oe, core_di, pad_di, pad_do, pad_oe;
  logic [NPIN-1:0] pre_do, pre_oe;
  int n_chk, n_fail;
  bit done;

  typedef struct {
    logic  exp;
    string req;
  } item_t;
  item_t exp_q[$];

  bscan_port #(.NPIN(NPIN)) i_bscan_port (
    .por_n(por_n), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .core_do(core_do), .core_oe(core_oe), .core_di(core_di),
    .pad_di(pad_di), .pad_do(pad_do), .pad_oe(pad_oe)
  );

  initial tck = 1'b0;
  always #10 tck = ~tck;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops one expected bit per shift cycle
  always @(negedge tck) begin
    #3;
    if (tdo_oe) begin
      if (exp_q.size() == 0) chk(1'b0, "R10 unexpected shift", 32'(tdo), 32'h0);
      else begin
        item_t it;
        it = exp_q.pop_front();
        chk(tdo == it.exp, it.req, 32'(tdo), 32'(it.exp));
      end
    end
  end

  task automatic step(input logic t, input logic d);
    @(negedge tck);
    #2;
    tms = t;
    tdi = d;
  endtask

  task automatic load_ir(input logic [2:0] op);
    exp_q.push_back('{1'b1, "R3"});
    exp_q.push_back('{1'b0, "R3"});
    exp_q.push_back('{1'b0, "R3"});
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    step(0, op[0]); step(0, op[1]); step(1, op[2]);
    step(1, 0); step(0, 0);
    #3;
  endtask

  task automatic shift_dr(input int len, input logic [63:0] din, input logic [63:0] exp, input string req);
    for (int k = 0; k < len; k++) exp_q.push_back('{exp[k], req});
    step(1, 0); step(0, 0); step(0, 0);
    for (int k = 0; k < len; k++) step(k == len - 1, din[k]);
    step(1, 0);
    @(posedge tck);
    #2;
    pre_do = pad_do;
    pre_oe = pad_oe;
    step(0, 0);
    #3;
  endtask

  function automatic logic [63:0] captured();
    logic [63:0] v = '0;
    for (int i = 0; i < NPIN; i++) begin
      v[3*i]   = core_oe[i];
      v[3*i+1] = core_do[i];
      v[3*i+2] = pad_di[i];
    end
    return v;
  endfunction

  function automatic logic [NPIN-1:0] lat_en(input logic [63:0] p);
    logic [NPIN-1:0] v;
    for (int i = 0; i < NPIN; i++) v[i] = p[3*i];
    return v;
  endfunction

  function automatic logic [NPIN-1:0] lat_do(input logic [63:0] p);
    logic [NPIN-1:0] v;
    for (int i = 0; i < NPIN; i++) v[i] = p[3*i+1];
    return v;
  endfunction

  task automatic check_follow(input string req);
    chk(pad_do == core_do, req, 32'(pad_do), 32'(core_do));
    chk(pad_oe == core_oe, req, 32'(pad_oe), 32'(core_oe));
  endtask

  task automatic bypass_scan(input logic [3:0] din, input string req);
    shift_dr(4, 64'(din), 64'({din[2:0], 1'b0}), req);
  endtask

  initial begin
    logic [63:0] p1, p2, p3;
    n_chk = 0; n_fail = 0; done = 0;
    por_n = 0; tms = 1; tdi = 0;
    core_do = 4'b1010; core_oe = 4'b0110; pad_di = 4'b0011;
    repeat (3) @(negedge tck);
    #2 por_n = 1;
    repeat (3) @(negedge tck);
    #5;
    // R1 reset state
    check_follow("R1");
    chk(tdo_oe == 1'b0 && tdo == 1'b0, "R1 tdo idle", {tdo_oe, tdo}, 0);
    chk(core_di == pad_di, "R13", 32'(core_di), 32'(pad_di));

    step(0, 0);
    #3;
    chk(tdo_oe == 1'b0, "R10 idle", 32'(tdo_oe), 0);

    // R3, R4: bypass instruction
    load_ir(3'b111);
    bypass_scan(4'b1101, "R4");
    check_follow("R4");

    // R5: private codes behave as bypass
    load_ir(3'b011);
    bypass_scan(4'b0110, "R5");
    check_follow("R5");
    load_ir(3'b100);
    bypass_scan(4'b1011, "R5");
    check_follow("R5");

    // R6, R12: sample captures chain, pads stay with core
    p1 = 64'hA5C;
    load_ir(3'b001);
    shift_dr(W, p1, captured(), "R6 R12");
    check_follow("R6");

    // R7: external test, code 000, latches preloaded by sample
    load_ir(3'b000);
    chk(pad_do == lat_do(p1), "R7 000 data", 32'(pad_do), 32'(lat_do(p1)));
    chk(pad_oe == lat_en(p1), "R7 000 enable", 32'(pad_oe), 32'(lat_en(p1)));
    core_do = 4'b0101; pad_di = 4'b1100;
    chk(core_di == pad_di, "R13", 32'(core_di), 32'(pad_di));
    p2 = 64'h3C9;
    shift_dr(W, p2, captured(), "R7 R12");
    // R11: half a cycle into Update-DR pads still old
    chk(pre_do == lat_do(p1) && pre_oe == lat_en(p1), "R11", {pre_do, pre_oe}, {lat_do(p1), lat_en(p1)});
    chk(pad_do == lat_do(p2), "R7 data", 32'(pad_do), 32'(lat_do(p2)));
    chk(pad_oe == lat_en(p2), "R7 enable", 32'(pad_oe), 32'(lat_en(p2)));

    // R7: code 010
    load_ir(3'b010);
    p3 = 64'h6B3;
    shift_dr(W, p3, captured(), "R7 010");
    chk(pad_do == lat_do(p3), "R7 010 data", 32'(pad_do), 32'(lat_do(p3)));
    chk(pad_oe == lat_en(p3), "R7 010 enable", 32'(pad_oe), 32'(lat_en(p3)));

    // R8: high impedance
    load_ir(3'b101);
    chk(pad_oe == '0, "R8 off", 32'(pad_oe), 0);
    bypass_scan(4'b1001, "R8");
    chk(pad_oe == '0, "R8 off after scan", 32'(pad_oe), 0);

    // R9: clamp keeps latched values, scans do not touch them
    load_ir(3'b110);
    chk(pad_do == lat_do(p3) && pad_oe == lat_en(p3), "R9", {pad_do, pad_oe}, {lat_do(p3), lat_en(p3)});
    bypass_scan(4'b0111, "R9");
    chk(pad_do == lat_do(p3) && pad_oe == lat_en(p3), "R9 after scan", {pad_do, pad_oe}, {lat_do(p3), lat_en(p3)});

    // R2: five TMS-high clocks from Pause-DR under external test
    load_ir(3'b000);
    step(1, 0); step(0, 0); step(1, 0); step(0, 0);
    for (int k = 0; k < 5; k++) step(1, 0);
    step(0, 0);
    #3;
    check_follow("R2");
    chk(tdo_oe == 1'b0, "R10 after reset", 32'(tdo_oe), 0);

    // R2: bypass instruction restored after the reset
    bypass_scan(4'b1110, "R2");
    check_follow("R2 pads");

    repeat (2) @(negedge tck);
    chk(exp_q.size() == 0, "R10 shift count", exp_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule